// File: doc/BRIEF.md
# Bidirectional Serial Word Buffer with Shared Error Flag

This block is the data path of a serial port that can be set to receive or to transmit. When receiving, bits arriving on a serial data pin are shifted into a word register and, once a full word has arrived, that word is placed in a two-entry buffer. The core or a DMA engine reads the buffer in arrival order. When transmitting, the core writes words into the same two-entry buffer. Each frame sync takes the oldest word and shifts it out on the data pin, most significant bit first.

The serial clock is given to the block as a one-cycle bit strobe in the system clock domain. A frame sync sampled on a strobe marks the first bit of a word. One status bit is shared by both directions. In receive mode it reports an overflow: a third word finished while the buffer was already full. In transmit mode it reports an underflow: a frame sync came while the buffer was empty. The bit is sticky and only disabling the port clears it. A level interrupt output shows that received data is waiting.

The direction select is changed only while the port is disabled.

Top module: `serport_buf`

## Requirements
- R1: In receive mode, a word starts on the strobe where the frame sync is high, with that strobe's data bit taken as bit 31 (MSB first). It completes on the 32nd strobe, and it enters the buffer on that same clock edge.
- R2: Received words are read in arrival order. `rd_data` shows the oldest word, and a read strobe while the buffer is not empty removes it so that the second word becomes the head.
- R3: The receive path holds two buffered words plus one in the shift register. If a third word completes while two are buffered and no read happens in that cycle, it replaces the second entry and the first entry is kept.
- R4: The overflow sets `err_flag` on the edge that takes the last bit of that third word. If a read happens in the same cycle, there is no overflow.
- R5: `buf_not_empty` is high exactly when the port is enabled in receive mode and at least one complete word is buffered.
- R6: In transmit mode, a strobe with frame sync high and a non-empty buffer takes the head word. `sdata_out` shows its bit 31 after that edge and each lower bit after each following strobe.
- R7: A transmit frame sync with an empty buffer sets `err_flag` and sends the previously sent word again, MSB first. If no word has been sent since the port was enabled, it sends all zeros.
- R8: `err_flag` is sticky: reads, writes and further frames do not clear it while the port stays enabled.
- R9: With `port_en` low, the block clears `err_flag`, empties both buffer entries, clears the shift registers and bit counters, and forces `sdata_out` to 0.
- R10: A transmit write while two words are buffered is ignored. It changes neither the buffered words nor `err_flag`.
- R11: A synchronous active-low `rst_n` puts the block in the same state as a disabled port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; low clears all state |
| dir_tx | input | 1 | 0 = receive, 1 = transmit |
| bit_tick | input | 1 | One-cycle serial bit strobe |
| fsync | input | 1 | Frame sync, sampled on a bit strobe |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data |
| wr_en | input | 1 | Core write strobe (transmit mode) |
| wr_data | input | 32 | Core write word |
| rd_en | input | 1 | Core/DMA read strobe (receive mode) |
| rd_data | output | 32 | Oldest buffered receive word |
| buf_not_empty | output | 1 | Receive data-waiting interrupt |
| err_flag | output | 1 | Overflow (receive) / underflow (transmit) status |

## Verification
The embedded assertions check the following on every cycle: the flag stays set while the port is enabled, it sets after every overflow or underflow condition, a disable clears it, the head entry is kept during an overwrite, a write to a full buffer is dropped, and the first transmit bit matches the loaded word. Some behaviour can only be shown by the bench's scenarios. These are the exact bit order on the wire, the arrival order of words through the buffer, the edge-exact moment the flag rises on the third word, the replay of the last sent word, and a read in the same cycle cancelling an overflow. The bench checks these against a queue model under random word traffic and random reads.

// File: rtl/spb_pkg.sv
// Package: shared constants and the direction encoding for the serial word buffer.
// Assumes a fixed two-entry buffer; word width is a top-level parameter.
package spb_pkg;
    typedef enum logic {
        SPB_RX = 1'b0,
        SPB_TX = 1'b1
    } spb_dir_e;

    localparam int unsigned SPB_DEPTH = 2;
endpackage

// File: rtl/spb_fifo2.sv
// Two-entry word buffer, oldest word at the head.
// It does what it is told: when full, a push without a pop overwrites the
// second entry and raises ovf. The caller gates any push it wants dropped.
module spb_fifo2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic [1:0]   count,
    output logic         ovf
);
    logic [W-1:0] ent0, ent1;
    logic [1:0]   cnt;
    logic         pop_ok;

    // Purpose: a pop only acts on a non-empty buffer; flag a full-buffer overwrite.
    always_comb begin
        pop_ok = pop && (cnt != 2'd0);
        ovf    = push && !pop_ok && (cnt == 2'd2);
    end

    // Purpose: update the entries and the occupancy for push, pop and overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent0 <= '0;
            ent1 <= '0;
            cnt  <= 2'd0;
        end else if (pop_ok) begin
            if (push) begin
                if (cnt == 2'd2) begin
                    ent0 <= ent1;
                    ent1 <= din;
                end else begin
                    ent0 <= din;
                end
            end else begin
                ent0 <= ent1;
                cnt  <= cnt - 2'd1;
            end
        end else if (push) begin
            case (cnt)
                2'd0:    begin ent0 <= din; cnt <= 2'd1; end
                2'd1:    begin ent1 <= din; cnt <= 2'd2; end
                default: ent1 <= din;
            endcase
        end
    end

    assign head  = ent0;
    assign count = cnt;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt != 2'd3); // R2
    AST_HEAD_KEPT_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ovf |=> ($stable(ent0) && cnt == 2'd2)); // R3
endmodule

// File: rtl/spb_rx_shift.sv
// Receive shifter: builds one word MSB first from serial bits.
// A frame sync on a strobe starts a word. done pulses combinationally on the
// strobe carrying the final bit, and word then holds the complete value.
module spb_rx_shift #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         fs,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int unsigned BCW = $clog2(W);
    localparam logic [BCW-1:0] LAST = BCW'(W - 1);

    logic [W-2:0]   sh;
    logic [BCW-1:0] bcnt;
    logic           active;

    // Purpose: detect the final bit of the word now being received.
    always_comb begin
        done = tick && !fs && active && (bcnt == LAST);
        word = {sh, din};
    end

    // Purpose: shift in bits, counting from the frame sync to the word end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh     <= '0;
            bcnt   <= '0;
            active <= 1'b0;
        end else if (tick) begin
            if (fs) begin
                sh     <= {{(W-2){1'b0}}, din};
                bcnt   <= BCW'(1);
                active <= 1'b1;
            end else if (active) begin
                if (bcnt == LAST) begin
                    active <= 1'b0;
                    bcnt   <= '0;
                end else begin
                    sh   <= {sh[W-3:0], din};
                    bcnt <= bcnt + BCW'(1);
                end
            end
        end
    end

    AST_RX_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> bcnt == '0); // R1
endmodule

// File: rtl/spb_tx_shift.sv
// Transmit shifter: loads a word on a frame-sync strobe and sends it MSB
// first, one bit per later strobe. After the last bit it drives zeros.
module spb_tx_shift #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         fs,
    input  logic [W-1:0] load_word,
    output logic         sout
);
    localparam int unsigned BCW = $clog2(W);

    logic [W-1:0]   sh;
    logic [BCW-1:0] rem;

    // Purpose: load on a frame sync, then shift one bit per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh  <= '0;
            rem <= '0;
        end else if (tick) begin
            if (fs) begin
                sh  <= load_word;
                rem <= BCW'(W - 1);
            end else if (rem != '0) begin
                sh  <= {sh[W-2:0], 1'b0};
                rem <= rem - BCW'(1);
            end else begin
                sh  <= '0;
            end
        end
    end

    assign sout = sh[W-1];

    AST_TX_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (tick && fs) |=> sout == $past(load_word[W-1])); // R6
endmodule

// File: rtl/serport_buf.sv
// Top of the serial word buffer. It selects the receive or transmit path,
// shares one two-entry buffer between them, and keeps the sticky
// overflow/underflow flag. It assumes dir_tx changes only while port_en is
// low, and that bit_tick is a single-cycle strobe in the clk domain.
module serport_buf #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_en,
    input  logic         dir_tx,
    input  logic         bit_tick,
    input  logic         fsync,
    input  logic         sdata_in,
    output logic         sdata_out,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         buf_not_empty,
    output logic         err_flag
);
    import spb_pkg::*;

    spb_dir_e     dir;
    logic         clr, rx_on, tx_on, tx_fs;
    logic         rx_done;
    logic [W-1:0] rx_word;
    logic         f_push, f_pop, f_ovf;
    logic [W-1:0] f_din, f_head, last_sent, tx_load;
    logic [1:0]   f_cnt;
    logic         unf;

    // Purpose: decode the mode and route the buffer controls for the active path.
    always_comb begin
        dir     = spb_dir_e'(dir_tx);
        clr     = !port_en;
        rx_on   = port_en && (dir == SPB_RX);
        tx_on   = port_en && (dir == SPB_TX);
        tx_fs   = tx_on && bit_tick && fsync;
        f_pop   = rx_on ? rd_en : tx_fs;
        f_push  = rx_on ? rx_done : (tx_on && wr_en && f_cnt != 2'd2);
        f_din   = rx_on ? rx_word : wr_data;
        unf     = tx_fs && (f_cnt == 2'd0);
        tx_load = (f_cnt != 2'd0) ? f_head : last_sent;
    end

    spb_rx_shift #(.W(W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr || !rx_on),
        .tick  (bit_tick),
        .fs    (fsync),
        .din   (sdata_in),
        .done  (rx_done),
        .word  (rx_word)
    );

    spb_fifo2 #(.W(W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (f_push),
        .pop   (f_pop),
        .din   (f_din),
        .head  (f_head),
        .count (f_cnt),
        .ovf   (f_ovf)
    );

    spb_tx_shift #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr || !tx_on),
        .tick      (bit_tick),
        .fs        (tx_fs),
        .load_word (tx_load),
        .sout      (sdata_out)
    );

    // Purpose: remember the last word sent so an underflow can replay it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            last_sent <= '0;
        end else if (tx_fs && f_cnt != 2'd0) begin
            last_sent <= f_head;
        end
    end

    // Purpose: sticky flag, set by an overflow or underflow, cleared only by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_flag <= 1'b0;
        end else if ((rx_on && f_ovf) || unf) begin
            err_flag <= 1'b1;
        end
    end

    assign rd_data       = rx_on ? f_head : '0;
    assign buf_not_empty = rx_on && (f_cnt != 2'd0);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && port_en) |=> err_flag); // R8
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!err_flag && f_cnt == 2'd0 && !sdata_out)); // R9
    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && rx_done && f_cnt == 2'd2 && !rd_en) |=> err_flag); // R4
    AST_UNF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fs && f_cnt == 2'd0) |=> err_flag); // R7
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n || !port_en)
        (tx_on && wr_en && f_cnt == 2'd2 && !tx_fs && !err_flag) |=>
        (f_cnt == 2'd2 && $stable(f_head) && !err_flag)); // R10
    AST_IRQ_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && rx_done) |=> (buf_not_empty || !rx_on)); // R5
endmodule

// File: tb/tb_serport_buf.sv
module tb_serport_buf;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         port_en = 1'b0, dir_tx = 1'b0, bit_tick = 1'b0, fsync = 1'b0;
    logic         sdata_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         sdata_out, buf_not_empty, err_flag;
    logic [W-1:0] rd_data;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    serport_buf #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .dir_tx(dir_tx),
        .bit_tick(bit_tick), .fsync(fsync), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .buf_not_empty(buf_not_empty),
        .err_flag(err_flag)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobe; inputs change 1 ns after an edge, outputs are sampled there too.
    task automatic tick(input logic fs, input logic d, input logic rd);
        bit_tick = 1'b1; fsync = fs; sdata_in = d; rd_en = rd;
        @(posedge clk); #1;
        bit_tick = 1'b0; fsync = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rx_word(input logic [W-1:0] w, input logic rd_last);
        for (int i = W - 1; i >= 0; i--) tick(i == W - 1, w[i], rd_last && i == 0);
    endtask

    task automatic do_read(output logic [W-1:0] d);
        d = rd_data; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [W-1:0] d);
        wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tx_frame(output logic [W-1:0] got);
        tick(1'b1, 1'b0, 1'b0);
        got[W-1] = sdata_out;
        for (int i = W - 2; i >= 0; i--) begin
            tick(1'b0, 1'b0, 1'b0);
            got[i] = sdata_out;
        end
    endtask

    task automatic set_mode(input logic tx);
        port_en = 1'b0; idle(1);
        dir_tx = tx; port_en = 1'b1; idle(1);
    endtask

    function automatic logic [W-1:0] flag_word(input logic b);
        return {{(W-1){1'b0}}, b};
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] q[$];
        logic [W-1:0] w0, w1, w2, d, got;
        logic         exp_err;
        void'($urandom(32'h1234abcd));

        idle(3);
        chk("R11 err after reset", flag_word(err_flag), 0);
        chk("R11 irq after reset", flag_word(buf_not_empty), 0);
        chk("R11 sout after reset", flag_word(sdata_out), 0);
        rst_n = 1'b1;
        set_mode(1'b0);

        // Directed receive: one word, interrupt rises on the last-bit edge
        w0 = $urandom;
        for (int i = W - 1; i >= 1; i--) tick(i == W - 1, w0[i], 1'b0);
        chk("R5 irq before last bit", flag_word(buf_not_empty), 0);
        tick(1'b0, w0[0], 1'b0);
        chk("R5 irq after word", flag_word(buf_not_empty), 1);
        chk("R1 rx word msb first", rd_data, w0);
        do_read(d);
        chk("R5 irq after drain", flag_word(buf_not_empty), 0);

        // Overflow: third word overwrites the second, flag on its last bit
        w0 = $urandom; w1 = $urandom; w2 = $urandom;
        rx_word(w0, 1'b0); rx_word(w1, 1'b0);
        for (int i = W - 1; i >= 1; i--) tick(i == W - 1, w2[i], 1'b0);
        chk("R4 no flag before last bit", flag_word(err_flag), 0);
        tick(1'b0, w2[0], 1'b0);
        chk("R4 flag on last bit", flag_word(err_flag), 1);
        do_read(d);
        chk("R3 head kept", d, w0);
        chk("R8 flag survives read", flag_word(err_flag), 1);
        do_read(d);
        chk("R3 second overwritten", d, w2);
        chk("R2 empty after two reads", flag_word(buf_not_empty), 0);
        port_en = 1'b0; idle(1);
        chk("R9 disable clears flag", flag_word(err_flag), 0);
        port_en = 1'b1; idle(1);

        // Same-cycle read cancels the overflow
        rx_word(w0, 1'b0); rx_word(w1, 1'b0);
        rx_word(w2, 1'b1);
        chk("R4 read same cycle no flag", flag_word(err_flag), 0);
        do_read(d); chk("R2 order after pop+push", d, w1);
        do_read(d); chk("R2 order last", d, w2);

        // Random receive traffic against a queue model
        set_mode(1'b0);
        q.delete(); exp_err = 1'b0;
        for (int k = 0; k < 40; k++) begin
            logic rdl;
            w0 = $urandom; rdl = 1'($urandom);
            if (rdl && q.size() > 0) chk("R2 random head", rd_data, q[0]);
            rx_word(w0, rdl);
            if (rdl && q.size() > 0) void'(q.pop_front());
            if (q.size() == 2) begin q[1] = w0; exp_err = 1'b1; end
            else q.push_back(w0);
            chk("R8 random flag", flag_word(err_flag), flag_word(exp_err));
            if ($urandom_range(0, 2) == 0 && q.size() > 0) begin
                do_read(d); chk("R2 random read", d, q.pop_front());
            end
            idle($urandom_range(0, 2));
        end
        while (q.size() > 0) begin do_read(d); chk("R2 drain", d, q.pop_front()); end

        // Transmit path
        set_mode(1'b1);
        w0 = $urandom; w1 = $urandom; w2 = $urandom;
        do_write(w0); do_write(w1); do_write(w2);
        chk("R10 full write no flag", flag_word(err_flag), 0);
        tx_frame(got); chk("R6 first word out", got, w0);
        tx_frame(got); chk("R10 second word not replaced", got, w1);
        chk("R7 no flag yet", flag_word(err_flag), 0);
        tick(1'b1, 1'b0, 1'b0);
        chk("R7 underflow flag", flag_word(err_flag), 1);
        got[W-1] = sdata_out;
        for (int i = W - 2; i >= 0; i--) begin tick(1'b0, 1'b0, 1'b0); got[i] = sdata_out; end
        chk("R7 replay last word", got, w1);
        do_write(w2);
        chk("R8 write keeps flag", flag_word(err_flag), 1);
        tx_frame(got); chk("R6 word after underflow", got, w2);
        port_en = 1'b0; idle(1);
        chk("R9 flag cleared", flag_word(err_flag), 0);
        chk("R9 sout low", flag_word(sdata_out), 0);
        port_en = 1'b1; idle(1);
        tx_frame(got); chk("R7 replay zero after enable", got, 0);

        // Random transmit traffic
        set_mode(1'b1);
        for (int k = 0; k < 20; k++) begin
            w0 = $urandom;
            do_write(w0);
            tx_frame(got); chk("R6 random tx word", got, w0);
        end
        chk("R8 no flag random tx", flag_word(err_flag), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule